// File: doc/BRIEF.md
# SPI Serial ROM Read Port with Hold

This block is the serial front end of a read-only memory of 4 M bytes. It behaves as an SPI slave with an active-low chip select, a serial clock, a serial data input, a data output that floats when not in use, and an active-low hold input. A host selects the block, shifts in a read opcode followed by a 24-bit byte address, and then clocks out data bytes, most significant bit first. Streaming continues through successive addresses until chip select is released. The stored bytes come from a fixed arithmetic function of the address, so no memory model is needed.

All four serial pins are brought into a fast system clock domain through synchronizers. Clock edges are found by comparing the synchronized serial clock with its value one cycle earlier. The hold input can pause a transfer at any point and resume it later with no loss of state. It is sampled only while the synchronized serial clock is low, so a hold that starts or ends during the high phase takes effect at the next low phase.

Top module: `spi_rom_slave`

## Requirements
- R1: While chip select (`csN`) is high, `so` is high impedance, `holdActive` is 0, and the protocol state is reset. After `rstN` is released the block is in this idle state.
- R2: Opcode 8'h03 (normal read), sent MSB first and sampled on rising `sclk` edges, is followed by a 24-bit address sent MSB first. The first data bit is driven on the falling edge that follows the last address bit.
- R3: Opcode 8'h0B (fast read) is followed by the 24-bit address and then 8 dummy rising edges. The first data bit is driven on the falling edge that follows the eighth dummy edge.
- R4: The data byte at byte address A (22 bits) is (A[7:0] ^ A[15:8] ^ {2'b00, A[21:16]} ^ 8'hA5). It is shifted out MSB first, one bit per falling edge.
- R5: After each byte the address increments and streaming continues. Address 0x3FFFFF is followed by 0x000000, and the two upper bits of the 24-bit address field have no effect.
- R6: After any other opcode, `so` stays high impedance until chip select rises.
- R7: Both SPI mode 0 (`sclk` low when chip select falls) and mode 3 (`sclk` high when chip select falls) give the same results.
- R8: Hold begins when `holdN` is low while chip select is low and `sclk` is low. If `sclk` is high when `holdN` falls, the falling edge that ends that high phase is still acted on, and hold begins right after it.
- R9: Hold ends when `holdN` is high while `sclk` is low. If `sclk` is high when `holdN` rises, hold persists, and the falling edge that ends that high phase is ignored.
- R10: While hold is active, `so` is high impedance and `holdActive` is 1. `sclk` and `mosi` are ignored, so the bit position, address and output bit resume unchanged after release.
- R11: Raising chip select during hold clears hold and all protocol state. A later transaction with `holdN` high behaves as one started from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| holdN | input | 1 | Active-low hold request |
| so | output | 1 | Serial data to the host, high impedance when not driving |
| holdActive | output | 1 | High while a hold condition is in force |

## Verification
The assertions assume that the host holds each serial pin steady for several system clocks around every change. They also assume that `mosi` is already settled when the synchronized rising edge of `sclk` arrives. The bench keeps to both: every pin changes on a falling system clock edge, and each `sclk` half period lasts eight system clocks, well above the synchronizer depth plus one. `holdN` changes are placed at chosen points of the `sclk` phase, so that both the immediate and the deferred start and end of hold take place.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_IGNORE
  } seqState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;
    logic shiftIn;
    logic capAddr;
    logic startData;
    logic emitBit;
  } dpStrobe_t;

  // stored content: a fixed mix of the address bytes
  function automatic logic [7:0] romByte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

endpackage

// File: rtl/spi_rom_sync.sv
module spi_rom_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage[s] <= RESET_VAL;
      end else if (s == 0) begin
        stage[s] <= asyncIn;
      end else begin
        stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/spi_rom_ctrl.sv
module spi_rom_ctrl
  import spi_rom_pkg::*;
#(
  parameter logic [7:0] CMD_NORMAL = 8'h03,
  parameter logic [7:0] CMD_FAST = 8'h0B,
  parameter int DUMMY_CYCLES = 8,
  parameter int ADDR_FIELD = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csAct,
  input  logic       riseEvt,
  input  logic       fallEvt,
  input  logic [7:0] opcodeNext,
  output dpStrobe_t  strobe,
  output seqState_t  seqState
);

  localparam int MAXA = (ADDR_FIELD > 8) ? ADDR_FIELD : 8;
  localparam int MAXC = (MAXA > DUMMY_CYCLES) ? MAXA : DUMMY_CYCLES;
  localparam int CW = $clog2(MAXC + 1);

  seqState_t stateNext;
  logic [CW-1:0] cnt, cntNext;
  logic fastSel, fastNext;

  always_comb begin
    strobe = '0;
    stateNext = seqState;
    cntNext = cnt;
    fastNext = fastSel;
    if (!csAct) begin
      strobe.clear = 1'b1;
      stateNext = ST_CMD;
      cntNext = '0;
      fastNext = 1'b0;
    end else begin
      case (seqState)
        ST_CMD: begin
          if (riseEvt) begin
            strobe.shiftIn = 1'b1;
            if (cnt == CW'(7)) begin
              cntNext = '0;
              if (opcodeNext == CMD_NORMAL) begin
                stateNext = ST_ADDR;
                fastNext = 1'b0;
              end else if (opcodeNext == CMD_FAST) begin
                stateNext = ST_ADDR;
                fastNext = 1'b1;
              end else begin
                stateNext = ST_IGNORE;
              end
            end else begin
              cntNext = cnt + 1'b1;
            end
          end
        end
        ST_ADDR: begin
          if (riseEvt) begin
            strobe.shiftIn = 1'b1;
            if (cnt == CW'(ADDR_FIELD - 1)) begin
              strobe.capAddr = 1'b1;
              cntNext = '0;
              if (fastSel && (DUMMY_CYCLES != 0)) begin
                stateNext = ST_DUMMY;
              end else begin
                stateNext = ST_DATA;
                strobe.startData = 1'b1;
              end
            end else begin
              cntNext = cnt + 1'b1;
            end
          end
        end
        ST_DUMMY: begin
          if (riseEvt) begin
            if (cnt == CW'(DUMMY_CYCLES - 1)) begin
              cntNext = '0;
              stateNext = ST_DATA;
              strobe.startData = 1'b1;
            end else begin
              cntNext = cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (fallEvt) strobe.emitBit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= ST_CMD;
      cnt <= '0;
      fastSel <= 1'b0;
    end else begin
      seqState <= stateNext;
      cnt <= cntNext;
      fastSel <= fastNext;
    end
  end

endmodule

// File: rtl/spi_rom_dpath.sv
module spi_rom_dpath
  import spi_rom_pkg::*;
#(
  parameter int ADDR_BITS = 22
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic                 mosi,
  output logic [7:0]           opcodeNext,
  output logic [ADDR_BITS-1:0] addrQ,
  output logic                 soBit,
  output logic                 driving
);

  localparam int SW = (ADDR_BITS > 8) ? ADDR_BITS : 8;

  logic [SW-1:0] shReg, shiftNext;
  logic [7:0]    curByte, romData;
  logic [2:0]    bitPos;
  logic          loadPending;
  logic [23:0]   addrExt;

  // address bits above the register width fall off the top of the shifter
  assign shiftNext = {shReg[SW-2:0], mosi};
  assign opcodeNext = shiftNext[7:0];

  always_comb begin
    addrExt = '0;
    addrExt[ADDR_BITS-1:0] = addrQ;
  end
  assign romData = romByte(addrExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      addrQ <= '0;
      curByte <= '0;
      bitPos <= '0;
      loadPending <= 1'b0;
      soBit <= 1'b0;
      driving <= 1'b0;
    end else if (strobe.clear) begin
      shReg <= '0;
      addrQ <= '0;
      curByte <= '0;
      bitPos <= '0;
      loadPending <= 1'b0;
      soBit <= 1'b0;
      driving <= 1'b0;
    end else begin
      if (strobe.shiftIn) shReg <= shiftNext;
      if (strobe.capAddr) addrQ <= shiftNext[ADDR_BITS-1:0];
      if (strobe.startData) begin
        loadPending <= 1'b1;
        driving <= 1'b0;
      end
      if (strobe.emitBit) begin
        driving <= 1'b1;
        if (loadPending) begin
          curByte <= romData;
          soBit <= romData[7];
          addrQ <= addrQ + 1'b1;
          bitPos <= 3'd6;
          loadPending <= 1'b0;
        end else begin
          soBit <= curByte[bitPos];
          if (bitPos == 3'd0) loadPending <= 1'b1;
          else bitPos <= bitPos - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_rom_slave.sv
module spi_rom_slave
  import spi_rom_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS = 22,
  parameter int ADDR_FIELD = 24,
  parameter int DUMMY_CYCLES = 8,
  parameter logic [7:0] CMD_NORMAL = 8'h03,
  parameter logic [7:0] CMD_FAST = 8'h0B
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic mosi,
  input  logic holdN,
  output logic so,
  output logic holdActive
);

  logic [3:0] syncOut;
  logic csS, holdS, sclkS, mosiS;
  logic csAct, sclkPrev, riseEvt, fallEvt, soOe;
  logic soBit, driving;
  logic [7:0] opcodeNext;
  logic [ADDR_BITS-1:0] addrQ;
  dpStrobe_t strobe;
  seqState_t seqState;

  spi_rom_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH(4),
    .RESET_VAL(4'b1100)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({csN, holdN, sclk, mosi}),
    .syncOut(syncOut)
  );

  assign {csS, holdS, sclkS, mosiS} = syncOut;
  assign csAct = ~csS;

  // hold state only changes while the serial clock is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      holdActive <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (!csAct) holdActive <= 1'b0;
      else if (!sclkS) holdActive <= ~holdS;
    end
  end

  assign riseEvt = csAct & ~holdActive & sclkS & ~sclkPrev;
  assign fallEvt = csAct & ~holdActive & ~sclkS & sclkPrev;

  spi_rom_ctrl #(
    .CMD_NORMAL(CMD_NORMAL),
    .CMD_FAST(CMD_FAST),
    .DUMMY_CYCLES(DUMMY_CYCLES),
    .ADDR_FIELD(ADDR_FIELD)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csAct(csAct),
    .riseEvt(riseEvt),
    .fallEvt(fallEvt),
    .opcodeNext(opcodeNext),
    .strobe(strobe),
    .seqState(seqState)
  );

  spi_rom_dpath #(
    .ADDR_BITS(ADDR_BITS)
  ) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .mosi(mosiS),
    .opcodeNext(opcodeNext),
    .addrQ(addrQ),
    .soBit(soBit),
    .driving(driving)
  );

  assign soOe = csAct & ~holdActive & driving & (seqState == ST_DATA);
  assign so = soOe ? soBit : 1'bz;

endmodule

// File: rtl/spi_rom_checker.sv
module spi_rom_checker
  import spi_rom_pkg::*;
#(
  parameter int ADDR_BITS = 22
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csAct,
  input logic                 sclkSync,
  input logic                 holdActive,
  input logic                 soOe,
  input seqState_t            seqState,
  input logic [ADDR_BITS-1:0] addrQ
);

  a_r1_idle_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $past(!csAct) |-> (seqState == ST_CMD) && (addrQ == '0));

  a_r6_ignore_floats: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_IGNORE) |-> !soOe);

  a_r8_hold_starts_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> !$past(sclkSync));

  a_r9_hold_ends_low: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(holdActive) && $past(csAct)) |-> !$past(sclkSync));

  a_r10_hold_floats: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |-> !soOe);

  a_r10_hold_freezes: assert property (@(posedge clk) disable iff (!rstN)
    ($past(holdActive) && $past(csAct)) |-> ($stable(addrQ) && $stable(seqState)));

endmodule

bind spi_rom_slave spi_rom_checker #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .csAct(csAct),
  .sclkSync(sclkS),
  .holdActive(holdActive),
  .soOe(soOe),
  .seqState(seqState),
  .addrQ(addrQ)
);

// File: tb/spi_rom_slave_tb.sv
module spi_rom_slave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic holdN = 1'b1;
  wire so;
  wire holdActive;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  spi_rom_slave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .holdN(holdN), .so(so), .holdActive(holdActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] expByte(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'hA5;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic openCs(input bit mode3);
    sclk = mode3;
    waitClk(HALF);
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic closeCs();
    sclk = 1'b0;
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendBit(input logic b);
    sclk = 1'b0;
    mosi = b;
    waitClk(HALF);
    sclk = 1'b1;
    waitClk(HALF);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic sendHeader(input logic [7:0] op, input logic [23:0] a);
    sendByte(op);
    sendByte(a[23:16]);
    sendByte(a[15:8]);
    sendByte(a[7:0]);
    if (op == 8'h0B) sendByte(8'h00);
  endtask

  task automatic readBit(output logic b);
    sclk = 1'b0;
    waitClk(HALF);
    b = so;
    sclk = 1'b1;
    waitClk(HALF);
  endtask

  task automatic readByte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) readBit(v[i]);
  endtask

  task automatic testReset();
    chk("R1 so idle", {7'd0, so}, {7'd0, 1'bz});
    chk("R1 hold idle", {7'd0, holdActive}, 8'd0);
  endtask

  task automatic testRead(input string req, input bit mode3, input logic [7:0] op,
                          input logic [23:0] a, input int n);
    logic [7:0] got;
    logic [21:0] addr = a[21:0];
    openCs(mode3);
    sendHeader(op, a);
    for (int k = 0; k < n; k++) begin
      readByte(got);
      chk(req, got, expByte(addr));
      addr = addr + 1'b1;
    end
    closeCs();
    chk("R1 so after deselect", {7'd0, so}, {7'd0, 1'bz});
  endtask

  task automatic testBadOpcode();
    logic [7:0] got;
    openCs(1'b0);
    sendHeader(8'h9F, 24'h000010);
    readByte(got);
    chk("R6 unknown opcode byte0", got, 8'bzzzzzzzz);
    readByte(got);
    chk("R6 unknown opcode byte1", got, 8'bzzzzzzzz);
    closeCs();
  endtask

  task automatic testHold();
    logic [7:0] got;
    logic [7:0] e0 = expByte(22'h000200);
    logic b;
    openCs(1'b0);
    sendHeader(8'h03, 24'h000200);
    for (int i = 7; i >= 5; i--) begin
      readBit(b);
      got[i] = b;
    end
    holdN = 1'b0;
    waitClk(HALF);
    chk("R8 deferred start while sclk high", {7'd0, holdActive}, 8'd0);
    sclk = 1'b0;
    waitClk(HALF);
    chk("R8 hold active once sclk low", {7'd0, holdActive}, 8'd1);
    chk("R10 so floats in hold", {7'd0, so}, {7'd0, 1'bz});
    for (int t = 0; t < 3; t++) begin
      sclk = 1'b1;
      mosi = ~mosi;
      waitClk(HALF);
      sclk = 1'b0;
      waitClk(HALF);
      chk("R10 so floats while clocked in hold", {7'd0, so}, {7'd0, 1'bz});
    end
    sclk = 1'b1;
    holdN = 1'b1;
    waitClk(HALF);
    chk("R9 deferred end while sclk high", {7'd0, holdActive}, 8'd1);
    sclk = 1'b0;
    waitClk(HALF);
    chk("R9 hold ends once sclk low", {7'd0, holdActive}, 8'd0);
    got[4] = so;
    sclk = 1'b1;
    waitClk(HALF);
    for (int i = 3; i >= 0; i--) begin
      readBit(b);
      got[i] = b;
    end
    chk("R10 byte resumes intact", got, e0);
    readByte(got);
    chk("R10 next byte after hold", got, expByte(22'h000201));
    closeCs();
  endtask

  task automatic testAbort();
    logic [7:0] got;
    logic b;
    openCs(1'b0);
    sendHeader(8'h03, 24'h000300);
    readBit(b);
    readBit(b);
    holdN = 1'b0;
    sclk = 1'b0;
    waitClk(HALF);
    chk("R11 hold entered", {7'd0, holdActive}, 8'd1);
    csN = 1'b1;
    waitClk(HALF);
    chk("R11 hold cleared by deselect", {7'd0, holdActive}, 8'd0);
    chk("R11 so floats after abort", {7'd0, so}, {7'd0, 1'bz});
    holdN = 1'b1;
    waitClk(HALF);
    openCs(1'b0);
    sendHeader(8'h03, 24'h001234);
    readByte(got);
    chk("R11 fresh transaction after abort", got, expByte(22'h001234));
    closeCs();
  endtask

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    testReset();
    testRead("R2 normal read mode 0", 1'b0, 8'h03, 24'h000010, 3);
    testRead("R7 normal read mode 3", 1'b1, 8'h03, 24'h00ABCD, 2);
    testRead("R3 fast read mode 0", 1'b0, 8'h0B, 24'h123456, 2);
    testRead("R7 fast read mode 3", 1'b1, 8'h0B, 24'h2A0F0F, 2);
    testRead("R4 content pattern", 1'b0, 8'h03, 24'h3C5A96, 4);
    testRead("R5 wrap at top", 1'b0, 8'h03, 24'h3FFFFF, 2);
    testRead("R5 upper bits ignored", 1'b0, 8'h03, 24'hC00005, 1);
    testBadOpcode();
    testHold();
    testAbort();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule